// File: doc/BRIEF.md
# ATM Receive Cell Header Classifier

This block sits at the start of the receive path of a cell-based link. It reads the 32-bit header of each arriving cell together with a flag from the header checker that says whether the header error check matched. From these it decides where the cell goes. A cell is dropped, delivered to a data channel, or diverted to the shared OAM channel. When a cell is diverted, its full header travels with it so that a completion record can carry it.

Only the low ten bits of the VCI select a channel. The generic flow control field, the VPI field and the upper VCI bits have no effect on the decision. Any path identifier is therefore usable as long as its low ten VCI bits are unique. The PTI field marks VC-level OAM cells, whatever their VCI. VCI values 3 and 4 mark VP-level OAM flows, and these go to their own channels like any other one-cell packet.

The decision is registered. It appears one clock after the input strobe and is held until the next strobe.

Top module: `atm_rx_classify`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. All result outputs load only when `in_valid` is high and hold their value otherwise.
- R2: A cell with `in_hec_ok` low is dropped, whatever its header. Result: class 6, `out_drop`=1, channel 0, `out_hdr_fwd`=0, `out_hdr`=0.
- R3: Header bits [31:28] (GFC), [27:20] (VPI) and [19:14] (upper VCI) have no effect on any output other than `out_hdr`.
- R4: With a good check, a cell whose VCI bits [13:4] are all zero is dropped as unassigned. Result: class 7, `out_drop`=1, channel 0.
- R5: With a good check and a nonzero low VCI, a PTI (bits [3:1]) of 4 gives class 4 and a PTI of 5 gives class 5. In both cases the channel is 0, `out_hdr_fwd`=1 and `out_hdr` equals the input header.
- R6: With a good check and a PTI other than 4 or 5, a low VCI of 3 gives class 2 on channel 3. A low VCI of 4 gives class 3 on channel 4. In both cases the header is not forwarded.
- R7: Every other cell is data. Result: class 1, channel equal to VCI bits [13:4], no drop, no forwarding, `out_hdr`=0. PTI values 6 and 7 are treated as data.
- R8: After reset, all outputs are zero. Class code 0 means no result yet.
- R9: The rules are checked in this priority order: bad check, unassigned VCI, VC-level OAM by PTI, VP-level OAM by VCI, data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header strobe |
| in_hdr | input | 32 | Cell header word |
| in_hec_ok | input | 1 | Header error check matched |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_chan | output | 10 | Destination channel |
| out_class | output | 3 | Class code |
| out_hdr_fwd | output | 1 | Header is forwarded with the cell |
| out_drop | output | 1 | Cell is discarded |
| out_hdr | output | 32 | Forwarded header, zero when not forwarded |

## Verification
The bench builds the block with its default parameters: a ten-bit channel field, OAM channel 0, and VP OAM identifiers 3 and 4. With ten bits, the channel extremes 1 and 1023 are within reach, and so are headers whose bit 14 (the lowest ignored VCI bit) is set next to an all-zero low field. A behavioural model predicts every output on every clock. Directed cells cover each priority collision, such as a bad check on an OAM header, or PTI 4 on VCI 3. A long random run mixes strobes, idle gaps and corrupted checks.

// File: rtl/atm_rx_cls_pkg.sv
package atm_rx_cls_pkg;

  typedef enum logic [2:0] {
    CLS_IDLE       = 3'd0,
    CLS_DATA       = 3'd1,
    CLS_VP_SEG     = 3'd2,
    CLS_VP_E2E     = 3'd3,
    CLS_VC_SEG     = 3'd4,
    CLS_VC_E2E     = 3'd5,
    CLS_BAD_HEC    = 3'd6,
    CLS_UNASSIGNED = 3'd7
  } cls_e;

  typedef struct packed {
    logic [3:0]  gfc;
    logic [7:0]  vpi;
    logic [15:0] vci;
    logic [2:0]  pti;
    logic        clp;
  } atm_hdr_t;

  localparam int HDR_W = $bits(atm_hdr_t);

  localparam logic [2:0] PTI_VC_SEG = 3'd4;
  localparam logic [2:0] PTI_VC_E2E = 3'd5;

  function automatic logic pti_is_vc_oam(input logic [2:0] pti);
    return (pti == PTI_VC_SEG) || (pti == PTI_VC_E2E);
  endfunction

  function automatic logic cls_drops(input cls_e c);
    return (c == CLS_BAD_HEC) || (c == CLS_UNASSIGNED);
  endfunction

  function automatic logic cls_forwards(input cls_e c);
    return (c == CLS_VC_SEG) || (c == CLS_VC_E2E);
  endfunction

endpackage

// File: rtl/atm_hdr_split.sv
module atm_hdr_split
  import atm_rx_cls_pkg::*;
#(
  parameter int VCI_W = 10
) (
  input  logic [HDR_W-1:0] hdr_word,
  output atm_hdr_t         fields,
  output logic [VCI_W-1:0] vci_low,
  output logic [2:0]       pti
);
  assign fields  = atm_hdr_t'(hdr_word);
  assign vci_low = fields.vci[VCI_W-1:0];
  assign pti     = fields.pti;
endmodule

// File: rtl/atm_cls_rules.sv
module atm_cls_rules
  import atm_rx_cls_pkg::*;
#(
  parameter int VCI_W      = 10,
  parameter int OAM_CHAN   = 0,
  parameter int VP_SEG_VCI = 3,
  parameter int VP_E2E_VCI = 4
) (
  input  logic             hec_ok,
  input  logic [VCI_W-1:0] vci_low,
  input  logic [2:0]       pti,
  output cls_e             cls,
  output logic [VCI_W-1:0] chan,
  output logic             hit_unassigned,
  output logic             hit_vc_oam,
  output logic             hit_vp_oam
);
  localparam logic [VCI_W-1:0] OAM_CH_V = VCI_W'(OAM_CHAN);
  localparam logic [VCI_W-1:0] VP_SEG_V = VCI_W'(VP_SEG_VCI);
  localparam logic [VCI_W-1:0] VP_E2E_V = VCI_W'(VP_E2E_VCI);

  assign hit_unassigned = (vci_low == '0);
  assign hit_vc_oam     = pti_is_vc_oam(pti);
  assign hit_vp_oam     = (vci_low == VP_SEG_V) || (vci_low == VP_E2E_V);

  always_comb begin
    cls  = CLS_DATA;
    chan = vci_low;
    if (!hec_ok) begin
      cls  = CLS_BAD_HEC;
      chan = '0;
    end else if (hit_unassigned) begin
      cls  = CLS_UNASSIGNED;
      chan = '0;
    end else if (hit_vc_oam) begin
      cls  = (pti == PTI_VC_SEG) ? CLS_VC_SEG : CLS_VC_E2E;
      chan = OAM_CH_V;
    end else if (hit_vp_oam) begin
      cls  = (vci_low == VP_SEG_V) ? CLS_VP_SEG : CLS_VP_E2E;
    end
  end
endmodule

// File: rtl/atm_cls_reg.sv
module atm_cls_reg
  import atm_rx_cls_pkg::*;
#(
  parameter int VCI_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  cls_e             cls_d,
  input  logic [VCI_W-1:0] chan_d,
  input  logic [HDR_W-1:0] hdr_d,
  output logic             valid_q,
  output cls_e             cls_q,
  output logic [VCI_W-1:0] chan_q,
  output logic             fwd_q,
  output logic             drop_q,
  output logic [HDR_W-1:0] hdr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cls_q   <= CLS_IDLE;
      chan_q  <= '0;
      fwd_q   <= 1'b0;
      drop_q  <= 1'b0;
      hdr_q   <= '0;
    end else begin
      valid_q <= load;
      if (load) begin
        cls_q  <= cls_d;
        chan_q <= chan_d;
        fwd_q  <= cls_forwards(cls_d);
        drop_q <= cls_drops(cls_d);
        hdr_q  <= cls_forwards(cls_d) ? hdr_d : '0;
      end
    end
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(chan_q) && $stable(cls_q) && $stable(hdr_q)));
  p_fwd_not_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_q && drop_q));
endmodule

// File: rtl/atm_rx_classify.sv
module atm_rx_classify
  import atm_rx_cls_pkg::*;
#(
  parameter int VCI_W      = 10,
  parameter int OAM_CHAN   = 0,
  parameter int VP_SEG_VCI = 3,
  parameter int VP_E2E_VCI = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_hdr,
  input  logic             in_hec_ok,
  output logic             out_valid,
  output logic [VCI_W-1:0] out_chan,
  output logic [2:0]       out_class,
  output logic             out_hdr_fwd,
  output logic             out_drop,
  output logic [31:0]      out_hdr
);
  atm_hdr_t         fields;
  logic [VCI_W-1:0] vci_low;
  logic [2:0]       pti;
  cls_e             cls_d;
  cls_e             cls_q;
  logic [VCI_W-1:0] chan_d;
  logic             hit_unassigned;
  logic             hit_vc_oam;
  logic             hit_vp_oam;

  atm_hdr_split #(.VCI_W(VCI_W)) u_split (
    .hdr_word (in_hdr),
    .fields   (fields),
    .vci_low  (vci_low),
    .pti      (pti)
  );

  atm_cls_rules #(
    .VCI_W(VCI_W), .OAM_CHAN(OAM_CHAN),
    .VP_SEG_VCI(VP_SEG_VCI), .VP_E2E_VCI(VP_E2E_VCI)
  ) u_rules (
    .hec_ok         (in_hec_ok),
    .vci_low        (vci_low),
    .pti            (pti),
    .cls            (cls_d),
    .chan           (chan_d),
    .hit_unassigned (hit_unassigned),
    .hit_vc_oam     (hit_vc_oam),
    .hit_vp_oam     (hit_vp_oam)
  );

  atm_cls_reg #(.VCI_W(VCI_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .cls_d   (cls_d),
    .chan_d  (chan_d),
    .hdr_d   (fields),
    .valid_q (out_valid),
    .cls_q   (cls_q),
    .chan_q  (out_chan),
    .fwd_q   (out_hdr_fwd),
    .drop_q  (out_drop),
    .hdr_q   (out_hdr)
  );

  assign out_class = cls_q;

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_bad_hec_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_hec_ok) |=> (out_drop && !out_hdr_fwd && out_chan == '0));
  p_unassigned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_hec_ok && hit_unassigned) |=> (out_class == 3'd7));
  p_vc_oam_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_hec_ok && !hit_unassigned && hit_vc_oam)
      |=> (out_hdr_fwd && out_hdr == $past(in_hdr)));
  p_vp_oam_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_hec_ok && !hit_vc_oam && hit_vp_oam)
      |=> (!out_hdr_fwd && out_chan == $past(vci_low)));
endmodule

// File: tb/atm_rx_classify_bench.sv
module atm_rx_classify_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_hdr = '0;
  logic        in_hec_ok = 1'b0;
  logic        out_valid;
  logic [9:0]  out_chan;
  logic [2:0]  out_class;
  logic        out_hdr_fwd;
  logic        out_drop;
  logic [31:0] out_hdr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string tag = "";

  int e_valid = 0, e_chan = 0, e_cls = 0, e_fwd = 0, e_drop = 0;
  logic [31:0] e_hdr = '0;

  always #2 clk = ~clk;

  atm_rx_classify u_atm_rx_classify (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr),
    .in_hec_ok(in_hec_ok), .out_valid(out_valid), .out_chan(out_chan),
    .out_class(out_class), .out_hdr_fwd(out_hdr_fwd), .out_drop(out_drop),
    .out_hdr(out_hdr)
  );

  // reference: written as a decision list, working on integers
  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid = 0; e_chan = 0; e_cls = 0; e_fwd = 0; e_drop = 0; e_hdr = '0;
    end else begin
      e_valid = in_valid ? 1 : 0;
      if (in_valid) begin
        int v, p;
        v = (int'(in_hdr) >> 4) % 1024;
        p = (int'(in_hdr) >> 1) % 8;
        e_fwd = 0; e_drop = 0; e_chan = 0;
        if (in_hec_ok == 1'b0) begin e_cls = 6; e_drop = 1; end
        else if (v == 0) begin e_cls = 7; e_drop = 1; end
        else if (p == 4 || p == 5) begin e_cls = p; e_fwd = 1; end
        else if (v == 3) begin e_cls = 2; e_chan = 3; end
        else if (v == 4) begin e_cls = 3; e_chan = 4; end
        else begin e_cls = 1; e_chan = v; end
        e_hdr = e_fwd ? in_hdr : 32'h0;
      end
    end
    #1;
    compare();
  end

  function automatic string req_of(int c, int rst);
    if (tag != "") return tag;
    if (rst == 0) return "R8";
    case (c)
      1: return "R7";
      2, 3: return "R6";
      4, 5: return "R5";
      6: return "R2";
      7: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic compare();
    total++;
    if (out_valid !== 1'(e_valid)) begin
      bad++;
      $display("FAIL R1 out_valid actual=%0b expected=%0d", out_valid, e_valid);
    end
    total++;
    if (out_class !== 3'(e_cls) || out_chan !== 10'(e_chan) ||
        out_hdr_fwd !== 1'(e_fwd) || out_drop !== 1'(e_drop) || out_hdr !== e_hdr) begin
      bad++;
      $display("FAIL %s actual cls=%0d ch=%0d fwd=%0b drop=%0b hdr=%h expected cls=%0d ch=%0d fwd=%0d drop=%0d hdr=%h",
               req_of(e_cls, rst_n), out_class, out_chan, out_hdr_fwd, out_drop, out_hdr,
               e_cls, e_chan, e_fwd, e_drop, e_hdr);
    end
  endtask

  function automatic logic [31:0] mk(int upper, int vci, int pti, int clp);
    return {upper[11:0], 6'(upper >> 12), vci[9:0], pti[2:0], clp[0]};
  endfunction

  task automatic send(logic [31:0] h, logic ok, string t);
    @(negedge clk);
    tag = t; in_valid = 1'b1; in_hdr = h; in_hec_ok = ok;
    @(negedge clk);
    in_valid = 1'b0; in_hdr = $urandom; in_hec_ok = 1'($urandom);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    send(mk(0, 37, 0, 0), 1'b1, "R7");
    send(mk(0, 1, 6, 1), 1'b1, "R7");
    send(mk(0, 1023, 7, 0), 1'b1, "R7");
    send(mk(0, 37, 0, 0), 1'b0, "R2");
    send(mk(0, 3, 4, 0), 1'b0, "R2");
    send(mk(0, 0, 0, 0), 1'b1, "R4");
    send(mk(262143, 0, 2, 1), 1'b1, "R3");
    send(mk(1, 0, 0, 0), 1'b1, "R3");
    send(mk(170000, 512, 0, 0), 1'b1, "R3");
    send(mk(0, 77, 4, 0), 1'b1, "R5");
    send(mk(99999, 200, 5, 1), 1'b1, "R5");
    send(mk(0, 3, 0, 0), 1'b1, "R6");
    send(mk(5, 4, 2, 0), 1'b1, "R6");
    send(mk(0, 3, 4, 0), 1'b1, "R9");
    send(mk(0, 4, 5, 0), 1'b1, "R9");
    send(mk(0, 0, 5, 0), 1'b1, "R9");
    @(negedge clk); tag = "R1";
    in_hdr = mk(0, 3, 4, 0); in_hec_ok = 1'b1;
    repeat (3) @(negedge clk);
    tag = "";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      in_valid  = 1'($urandom % 4 != 0);
      in_hec_ok = 1'($urandom % 8 != 0);
      in_hdr    = mk(int'($urandom % 262144), int'($urandom % 8), int'($urandom % 8), 0);
      if ($urandom % 2 == 1) in_hdr[13:4] = 10'($urandom);
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule